// File: doc/BRIEF.md
# Frame Identifier Continuity Monitor

This block watches two streams of frame identifiers in an image acquisition path. One is seen where frames enter the path and one where they leave it. Each leaving frame is sorted into one of four classes: in order, gap, duplicate or reorder. The sorting is done against the highest identifier already seen at the output. Three separate saturating counters total the dropped frames, the duplicates and the reorders. A run passes while all three counters stay at zero. The first anomaly after a clear is frozen in a snapshot that holds the identifier that was due, the identifier that arrived, the output timestamp and the class.

Entry timestamps are written into a small table indexed by the low identifier bits. Each entry is tagged with the upper bits. When a frame leaves, the table is searched for its identifier. On a hit the block reports the frame's transit time as the output timestamp minus the stored entry timestamp. A single `clear` input zeroes the counters and re-arms the snapshot.

There are two state machines. The sequence tracker has the states TRK_WAIT_FIRST and TRK_RUN. Its transition is "first output frame" (WAIT_FIRST to RUN), and it stays in RUN until reset. The snapshot keeper has the states SNP_ARMED and SNP_HELD. Its transitions are "anomaly while armed" (ARMED to HELD) and "clear" (HELD to ARMED).

Top module: `fid_continuity_mon`

## Requirements
- R1: After reset, all three counters are 0, `clean` is 1, and `frm_done`, `lat_valid` and `snap_valid` are 0.
- R2: Every cycle with `out_valid` high yields `frm_done` high for exactly one cycle, on the next clock edge, with `frm_kind` encoded as 0 in order, 1 gap, 2 duplicate, 3 reorder. The difference d = `out_id` minus the last accepted ID is taken modulo 2^ID_W, so d = 1 across the wrap from all-ones to zero is in order.
- R3: The first output frame after reset is classified in order and becomes the reference ID.
- R4: When 2 <= d < 2^(ID_W-1) the frame is a gap: d-1 is added to `gap_cnt` and the reference advances to `out_id`.
- R5: When d = 0 the frame is a duplicate: `dup_cnt` increments and the reference is unchanged.
- R6: When d >= 2^(ID_W-1), including exactly half range, the frame is a reorder: `reord_cnt` increments and the reference is unchanged.
- R7: `clean` is 1 exactly when all three counters are zero.
- R8: The timestamp table has 2^TAB_AW entries, indexed by `ent_id[TAB_AW-1:0]` and tagged with the remaining upper bits. A later entry with the same index overwrites the earlier one. When an output frame's index and tag match an entry written at least one cycle earlier, `lat_valid` rises together with `frm_done` and `lat_ticks` = `out_ts` - entry ts (mod 2^TS_W). Otherwise `lat_valid` stays 0.
- R9: The first non-in-order frame while armed sets `snap_valid` and captures `snap_exp_id` = reference + 1, `snap_got_id` = `out_id`, `snap_ts` = `out_ts` and `snap_kind` = class. These fields then hold through later anomalies.
- R10: `clear` zeroes the counters and the snapshot fields and re-arms the snapshot on the next edge. It takes priority over an event in the same cycle. It leaves the reference ID and the timestamp table untouched.
- R11: Each counter saturates at 2^CNT_W-1 rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Zero counters, re-arm snapshot |
| ent_valid | input | 1 | Entry-side frame strobe |
| ent_id | input | ID_W | Entry-side frame identifier |
| ent_ts | input | TS_W | Entry-side timestamp |
| out_valid | input | 1 | Output-side frame strobe |
| out_id | input | ID_W | Output-side frame identifier |
| out_ts | input | TS_W | Output-side timestamp |
| frm_done | output | 1 | Classification result valid |
| frm_kind | output | 2 | Class: 0 in order, 1 gap, 2 duplicate, 3 reorder |
| lat_valid | output | 1 | Transit time valid |
| lat_ticks | output | TS_W | Output ts minus entry ts |
| gap_cnt | output | CNT_W | Total dropped frames |
| dup_cnt | output | CNT_W | Duplicate frames |
| reord_cnt | output | CNT_W | Reordered frames |
| clean | output | 1 | All counters zero |
| snap_valid | output | 1 | Snapshot holds a capture |
| snap_kind | output | 2 | Captured class |
| snap_exp_id | output | ID_W | Captured expected ID |
| snap_got_id | output | ID_W | Captured received ID |
| snap_ts | output | TS_W | Captured output timestamp |

## Verification
All results for an output frame arrive together one clock edge after the cycle in which `out_valid` was sampled: the class, transit time, counters and snapshot. `clean` follows the counters in that same cycle. A `clear` sampled at an edge shows its effect right after that edge. The bench drives inputs on the falling edge. A behavioural model updates on the rising edge from the same inputs, and every output is compared with the model at the following falling edge, which is exactly when the one-cycle result has settled. Directed checks at those same falling edges pin down the wrap, half-range, aliasing, same-cycle clear and saturation cases.

// File: rtl/fid_mon_pkg.sv
package fid_mon_pkg;

    typedef enum logic [1:0] {
        K_INORDER = 2'd0,
        K_GAP     = 2'd1,
        K_DUP     = 2'd2,
        K_REORD   = 2'd3
    } kind_e;

    typedef enum logic {
        TRK_WAIT_FIRST = 1'b0,
        TRK_RUN        = 1'b1
    } trk_state_e;

    typedef enum logic {
        SNP_ARMED = 1'b0,
        SNP_HELD  = 1'b1
    } snp_state_e;

    localparam int NUM_CNT = 3;
    localparam int CI_GAP  = 0;
    localparam int CI_DUP  = 1;
    localparam int CI_REO  = 2;

endpackage

// File: rtl/fid_seq_tracker.sv
module fid_seq_tracker
    import fid_mon_pkg::*;
#(
    parameter int ID_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [ID_W-1:0] in_id,
    output kind_e           kind,
    output logic [ID_W-1:0] drop_n,
    output logic [ID_W-1:0] exp_id
);

    localparam logic [ID_W-1:0] ONE = ID_W'(1);

    trk_state_e      st_q, st_d;
    logic [ID_W-1:0] last_q, last_d;
    logic [ID_W-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= TRK_WAIT_FIRST;
            last_q <= '0;
        end else begin
            st_q   <= st_d;
            last_q <= last_d;
        end
    end

    always_comb begin
        diff   = in_id - last_q;
        exp_id = last_q + ONE;
        drop_n = '0;
        kind   = K_INORDER;
        st_d   = st_q;
        last_d = last_q;
        unique case (st_q)
            TRK_WAIT_FIRST: begin
                if (in_valid) begin
                    st_d   = TRK_RUN;
                    last_d = in_id;
                end
            end
            TRK_RUN: begin
                if (diff == '0) begin
                    kind = K_DUP;
                end else if (diff[ID_W-1]) begin
                    kind = K_REORD;
                end else if (diff == ONE) begin
                    kind = K_INORDER;
                    if (in_valid) last_d = in_id;
                end else begin
                    kind   = K_GAP;
                    drop_n = diff - ONE;
                    if (in_valid) last_d = in_id;
                end
            end
            default: st_d = TRK_WAIT_FIRST;
        endcase
    end

endmodule

// File: rtl/fid_ts_table.sv
module fid_ts_table #(
    parameter int ID_W = 16,
    parameter int TS_W = 32,
    parameter int AW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_id,
    input  logic [TS_W-1:0] wr_ts,
    input  logic            rd_en,
    input  logic [ID_W-1:0] rd_id,
    input  logic [TS_W-1:0] rd_ts,
    output logic            lat_valid,
    output logic [TS_W-1:0] lat_val
);

    localparam int DEPTH = 1 << AW;
    localparam int TAG_W = ID_W - AW;

    logic [TS_W-1:0]  ts_mem  [DEPTH];
    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic             vld_mem [DEPTH];

    logic [AW-1:0]    wr_idx, rd_idx;
    logic [TAG_W-1:0] wr_tag, rd_tag;
    logic             hit;

    assign wr_idx = wr_id[AW-1:0];
    assign wr_tag = wr_id[ID_W-1:AW];
    assign rd_idx = rd_id[AW-1:0];
    assign rd_tag = rd_id[ID_W-1:AW];

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_mem[e] <= 1'b0;
                tag_mem[e] <= '0;
                ts_mem[e]  <= '0;
            end else if (wr_en && (wr_idx == AW'(e))) begin
                vld_mem[e] <= 1'b1;
                tag_mem[e] <= wr_tag;
                ts_mem[e]  <= wr_ts;
            end
        end
    end

    assign hit = vld_mem[rd_idx] && (tag_mem[rd_idx] == rd_tag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_valid <= 1'b0;
            lat_val   <= '0;
        end else begin
            lat_valid <= rd_en && hit;
            if (rd_en) lat_val <= rd_ts - ts_mem[rd_idx];
        end
    end

endmodule

// File: rtl/fid_evt_counters.sv
module fid_evt_counters
    import fid_mon_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int ID_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             ev_valid,
    input  kind_e            kind,
    input  logic [ID_W-1:0]  drop_n,
    output logic [CNT_W-1:0] gap_cnt,
    output logic [CNT_W-1:0] dup_cnt,
    output logic [CNT_W-1:0] reord_cnt
);

    localparam int SUM_W = ((CNT_W > ID_W) ? CNT_W : ID_W) + 1;
    localparam logic [SUM_W-1:0] CAP = {{(SUM_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

    logic [SUM_W-1:0] inc   [NUM_CNT];
    logic [CNT_W-1:0] cnt_q [NUM_CNT];

    always_comb begin
        inc[CI_GAP] = (ev_valid && kind == K_GAP)   ? SUM_W'(drop_n) : '0;
        inc[CI_DUP] = (ev_valid && kind == K_DUP)   ? SUM_W'(1)      : '0;
        inc[CI_REO] = (ev_valid && kind == K_REORD) ? SUM_W'(1)      : '0;
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic [SUM_W-1:0] sum_w;
        assign sum_w = SUM_W'(cnt_q[i]) + inc[i];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q[i] <= '0;
            else if (clear)        cnt_q[i] <= '0;
            else if (sum_w > CAP)  cnt_q[i] <= '1;
            else                   cnt_q[i] <= sum_w[CNT_W-1:0];
        end
    end

    assign gap_cnt   = cnt_q[CI_GAP];
    assign dup_cnt   = cnt_q[CI_DUP];
    assign reord_cnt = cnt_q[CI_REO];

endmodule

// File: rtl/fid_snapshot.sv
module fid_snapshot
    import fid_mon_pkg::*;
#(
    parameter int ID_W = 16,
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            ev_valid,
    input  kind_e           kind,
    input  logic [ID_W-1:0] exp_id,
    input  logic [ID_W-1:0] got_id,
    input  logic [TS_W-1:0] ts,
    output logic            snap_valid,
    output logic [1:0]      snap_kind,
    output logic [ID_W-1:0] snap_exp_id,
    output logic [ID_W-1:0] snap_got_id,
    output logic [TS_W-1:0] snap_ts
);

    snp_state_e st_q, st_d;
    logic       cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SNP_ARMED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        cap  = 1'b0;
        unique case (st_q)
            SNP_ARMED: begin
                if (!clear && ev_valid && kind != K_INORDER) begin
                    cap  = 1'b1;
                    st_d = SNP_HELD;
                end
            end
            SNP_HELD: begin
                if (clear) st_d = SNP_ARMED;
            end
            default: st_d = SNP_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_kind   <= '0;
            snap_exp_id <= '0;
            snap_got_id <= '0;
            snap_ts     <= '0;
        end else if (clear) begin
            snap_kind   <= '0;
            snap_exp_id <= '0;
            snap_got_id <= '0;
            snap_ts     <= '0;
        end else if (cap) begin
            snap_kind   <= kind;
            snap_exp_id <= exp_id;
            snap_got_id <= got_id;
            snap_ts     <= ts;
        end
    end

    assign snap_valid = (st_q == SNP_HELD);

endmodule

// File: rtl/fid_continuity_mon.sv
module fid_continuity_mon
    import fid_mon_pkg::*;
#(
    parameter int ID_W    = 16,
    parameter int TS_W    = 32,
    parameter int CNT_W   = 16,
    parameter int TAB_AW  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             ent_valid,
    input  logic [ID_W-1:0]  ent_id,
    input  logic [TS_W-1:0]  ent_ts,
    input  logic             out_valid,
    input  logic [ID_W-1:0]  out_id,
    input  logic [TS_W-1:0]  out_ts,
    output logic             frm_done,
    output logic [1:0]       frm_kind,
    output logic             lat_valid,
    output logic [TS_W-1:0]  lat_ticks,
    output logic [CNT_W-1:0] gap_cnt,
    output logic [CNT_W-1:0] dup_cnt,
    output logic [CNT_W-1:0] reord_cnt,
    output logic             clean,
    output logic             snap_valid,
    output logic [1:0]       snap_kind,
    output logic [ID_W-1:0]  snap_exp_id,
    output logic [ID_W-1:0]  snap_got_id,
    output logic [TS_W-1:0]  snap_ts
);

    kind_e           cls_kind;
    logic [ID_W-1:0] cls_drop;
    logic [ID_W-1:0] cls_exp;

    fid_seq_tracker #(.ID_W(ID_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (out_valid),
        .in_id    (out_id),
        .kind     (cls_kind),
        .drop_n   (cls_drop),
        .exp_id   (cls_exp)
    );

    fid_ts_table #(.ID_W(ID_W), .TS_W(TS_W), .AW(TAB_AW)) u_tab (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ent_valid),
        .wr_id     (ent_id),
        .wr_ts     (ent_ts),
        .rd_en     (out_valid),
        .rd_id     (out_id),
        .rd_ts     (out_ts),
        .lat_valid (lat_valid),
        .lat_val   (lat_ticks)
    );

    fid_evt_counters #(.CNT_W(CNT_W), .ID_W(ID_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .ev_valid  (out_valid),
        .kind      (cls_kind),
        .drop_n    (cls_drop),
        .gap_cnt   (gap_cnt),
        .dup_cnt   (dup_cnt),
        .reord_cnt (reord_cnt)
    );

    fid_snapshot #(.ID_W(ID_W), .TS_W(TS_W)) u_snp (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .ev_valid    (out_valid),
        .kind        (cls_kind),
        .exp_id      (cls_exp),
        .got_id      (out_id),
        .ts          (out_ts),
        .snap_valid  (snap_valid),
        .snap_kind   (snap_kind),
        .snap_exp_id (snap_exp_id),
        .snap_got_id (snap_got_id),
        .snap_ts     (snap_ts)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_done <= 1'b0;
            frm_kind <= '0;
        end else begin
            frm_done <= out_valid;
            if (out_valid) frm_kind <= cls_kind;
        end
    end

    assign clean = (gap_cnt == '0) && (dup_cnt == '0) && (reord_cnt == '0);

endmodule

// File: rtl/fid_continuity_mon_chk.sv
module fid_continuity_mon_chk #(
    parameter int ID_W  = 16,
    parameter int TS_W  = 32,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             out_valid,
    input logic             frm_done,
    input logic [1:0]       frm_kind,
    input logic             lat_valid,
    input logic [CNT_W-1:0] gap_cnt,
    input logic [CNT_W-1:0] dup_cnt,
    input logic [CNT_W-1:0] reord_cnt,
    input logic             snap_valid,
    input logic [ID_W-1:0]  snap_got_id,
    input logic [TS_W-1:0]  snap_ts
);

    AST_DONE_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> frm_done) else $error("done missing"); // R2

    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |=> !frm_done) else $error("spurious done"); // R2

    AST_GAP_NONDECREASE: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> gap_cnt >= $past(gap_cnt)) else $error("gap count fell"); // R11

    AST_DUP_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_kind == 2'd2 && !$past(clear)) |-> dup_cnt != '0) else $error("dup lost"); // R5

    AST_REORD_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_kind == 2'd3 && !$past(clear)) |-> reord_cnt != '0) else $error("reorder lost"); // R6

    AST_LAT_WITH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        lat_valid |-> frm_done) else $error("latency without frame"); // R8

    AST_SNAP_ON_ANOMALY: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_kind != 2'd0 && !$past(clear)) |-> snap_valid) else $error("snapshot missed"); // R9

    AST_SNAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_valid && !clear) |=> (snap_valid && $stable(snap_got_id) && $stable(snap_ts)))
        else $error("snapshot changed"); // R9

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (gap_cnt == '0 && dup_cnt == '0 && reord_cnt == '0 && !snap_valid))
        else $error("clear ineffective"); // R10

endmodule

bind fid_continuity_mon fid_continuity_mon_chk #(
    .ID_W(ID_W), .TS_W(TS_W), .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .out_valid   (out_valid),
    .frm_done    (frm_done),
    .frm_kind    (frm_kind),
    .lat_valid   (lat_valid),
    .gap_cnt     (gap_cnt),
    .dup_cnt     (dup_cnt),
    .reord_cnt   (reord_cnt),
    .snap_valid  (snap_valid),
    .snap_got_id (snap_got_id),
    .snap_ts     (snap_ts)
);

// File: tb/fid_continuity_mon_bench.sv
module fid_continuity_mon_bench;

    localparam int ID_W = 16;
    localparam int TS_W = 32;
    localparam int CNT_W = 16;
    localparam int TAB_AW = 4;
    localparam int SAT = 65535;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0;
    logic ent_valid = 1'b0;
    logic [ID_W-1:0] ent_id = '0;
    logic [TS_W-1:0] ent_ts = '0;
    logic out_valid = 1'b0;
    logic [ID_W-1:0] out_id = '0;
    logic [TS_W-1:0] out_ts = '0;

    logic frm_done, lat_valid, clean, snap_valid;
    logic [1:0] frm_kind, snap_kind;
    logic [TS_W-1:0] lat_ticks, snap_ts;
    logic [CNT_W-1:0] gap_cnt, dup_cnt, reord_cnt;
    logic [ID_W-1:0] snap_exp_id, snap_got_id;

    always #4 clk = ~clk;

    fid_continuity_mon #(.ID_W(ID_W), .TS_W(TS_W), .CNT_W(CNT_W), .TAB_AW(TAB_AW))
    u_fid_continuity_mon (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .ent_valid(ent_valid), .ent_id(ent_id), .ent_ts(ent_ts),
        .out_valid(out_valid), .out_id(out_id), .out_ts(out_ts),
        .frm_done(frm_done), .frm_kind(frm_kind),
        .lat_valid(lat_valid), .lat_ticks(lat_ticks),
        .gap_cnt(gap_cnt), .dup_cnt(dup_cnt), .reord_cnt(reord_cnt), .clean(clean),
        .snap_valid(snap_valid), .snap_kind(snap_kind),
        .snap_exp_id(snap_exp_id), .snap_got_id(snap_got_id), .snap_ts(snap_ts)
    );

    int n_run = 0;
    int n_fail = 0;

    task automatic chk(string req, string what, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_started;
    bit [15:0]   m_last;
    int          m_gap, m_dup, m_reo;
    bit          m_sv;
    bit [1:0]    m_sk;
    bit [15:0]   m_se, m_sg;
    int unsigned m_sts;
    bit          m_tv  [16];
    bit [11:0]   m_tg  [16];
    int unsigned m_tts [16];
    bit          e_done, e_latv;
    bit [1:0]    e_kind;
    int unsigned e_lat;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_started = 0; m_last = 0; m_gap = 0; m_dup = 0; m_reo = 0;
            m_sv = 0; m_sk = 0; m_se = 0; m_sg = 0; m_sts = 0;
            e_done = 0; e_latv = 0; e_kind = 0; e_lat = 0;
            for (int i = 0; i < 16; i++) begin m_tv[i] = 0; m_tg[i] = 0; m_tts[i] = 0; end
        end else begin
            e_done = out_valid;
            e_latv = 0;
            if (out_valid) begin
                bit [15:0] d;
                bit [1:0] k;
                int idx;
                idx = int'(out_id[3:0]);
                if (m_tv[idx] && m_tg[idx] == out_id[15:4]) begin
                    e_latv = 1;
                    e_lat = out_ts - m_tts[idx];
                end
                d = out_id - m_last;
                if (!m_started) begin k = 0; m_started = 1; m_last = out_id; end
                else if (d == 0) k = 2;
                else if (d >= 16'd32768) k = 3;
                else if (d == 1) begin k = 0; end
                else k = 1;
                e_kind = k;
                if (!clear) begin
                    if (k == 1) m_gap = (m_gap + int'(d) - 1 > SAT) ? SAT : m_gap + int'(d) - 1;
                    if (k == 2) m_dup = (m_dup + 1 > SAT) ? SAT : m_dup + 1;
                    if (k == 3) m_reo = (m_reo + 1 > SAT) ? SAT : m_reo + 1;
                    if (!m_sv && k != 0) begin
                        m_sv = 1; m_sk = k; m_se = m_last + 16'd1; m_sg = out_id; m_sts = out_ts;
                    end
                end
                if (k == 0 || k == 1) m_last = out_id;
            end
            if (clear) begin
                m_gap = 0; m_dup = 0; m_reo = 0;
                m_sv = 0; m_sk = 0; m_se = 0; m_sg = 0; m_sts = 0;
            end
            if (ent_valid) begin
                m_tv[ent_id[3:0]] = 1;
                m_tg[ent_id[3:0]] = ent_id[15:4];
                m_tts[ent_id[3:0]] = ent_ts;
            end
        end
    end

    bit cmp_on = 0;
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2", "frm_done", frm_done, e_done);
            if (e_done) chk("R2", "frm_kind", frm_kind, e_kind);
            chk("R4", "gap_cnt", gap_cnt, m_gap);
            chk("R5", "dup_cnt", dup_cnt, m_dup);
            chk("R6", "reord_cnt", reord_cnt, m_reo);
            chk("R7", "clean", clean, (m_gap == 0 && m_dup == 0 && m_reo == 0));
            chk("R8", "lat_valid", lat_valid, e_latv);
            if (e_latv) chk("R8", "lat_ticks", lat_ticks, e_lat);
            chk("R9", "snap_valid", snap_valid, m_sv);
            chk("R9", "snap_kind", snap_kind, m_sk);
            chk("R9", "snap_exp_id", snap_exp_id, m_se);
            chk("R9", "snap_got_id", snap_got_id, m_sg);
            chk("R9", "snap_ts", snap_ts, m_sts);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle_inputs();
        clear = 0; ent_valid = 0; out_valid = 0;
    endtask

    task automatic cyc(bit c, bit ev, int eid, int ets, bit ov, int oid, int ots);
        clear = c; ent_valid = ev; ent_id = ID_W'(eid); ent_ts = TS_W'(ets);
        out_valid = ov; out_id = ID_W'(oid); out_ts = TS_W'(ots);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic ent(int id, int ts);  cyc(0, 1, id, ts, 0, 0, 0); endtask
    task automatic outp(int id, int ts); cyc(0, 0, 0, 0, 1, id, ts); endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "gap_cnt", gap_cnt, 0);
        chk("R1", "dup_cnt", dup_cnt, 0);
        chk("R1", "reord_cnt", reord_cnt, 0);
        chk("R1", "clean", clean, 1);
        chk("R1", "frm_done", frm_done, 0);
        chk("R1", "lat_valid", lat_valid, 0);
        chk("R1", "snap_valid", snap_valid, 0);
        cmp_on = 1;

        for (int i = 0; i < 6; i++) ent(i, 100 + i);
        outp(0, 500);
        chk("R3", "first frame kind", frm_kind, 0);
        chk("R8", "first latency", lat_ticks, 400);
        for (int i = 1; i < 6; i++) outp(i, 500 + i);
        chk("R7", "clean after in-order run", clean, 1);

        for (int i = 6; i < 11; i++) ent(i, 200 + i);
        outp(6, 600);
        outp(9, 609);
        chk("R4", "gap kind", frm_kind, 1);
        chk("R4", "gap count", gap_cnt, 2);
        chk("R9", "snap exp", snap_exp_id, 7);
        chk("R9", "snap got", snap_got_id, 9);
        chk("R9", "snap ts", snap_ts, 609);
        outp(9, 610);
        chk("R5", "dup count", dup_cnt, 1);
        chk("R9", "snap held", snap_got_id, 9);
        chk("R7", "clean low", clean, 0);
        outp(7, 611);
        chk("R6", "reorder count", reord_cnt, 1);
        outp(10, 612);
        chk("R6", "reference kept", frm_kind, 0);

        cyc(1, 0, 0, 0, 0, 0, 0);
        chk("R10", "counters cleared", gap_cnt + dup_cnt + reord_cnt, 0);
        chk("R10", "snap rearmed", snap_valid, 0);
        outp(12, 700);
        chk("R10", "snap recapture exp", snap_exp_id, 11);
        chk("R8", "no entry no latency", lat_valid, 0);

        ent(40, 300);
        outp(8, 701);
        chk("R8", "aliased tag miss", lat_valid, 0);

        cyc(1, 0, 0, 0, 1, 12, 702);
        chk("R10", "same-cycle clear dup", dup_cnt, 0);
        chk("R10", "same-cycle clear snap", snap_valid, 0);
        chk("R2", "same-cycle clear kind", frm_kind, 2);

        outp(32000, 800);
        outp(63000, 801);
        outp(65535, 802);
        outp(0, 803);
        chk("R2", "wrap in order", frm_kind, 0);
        outp(30000, 804);
        chk("R11", "gap saturates", gap_cnt, SAT);
        outp(62768, 805);
        chk("R6", "half range reorder", frm_kind, 3);
        outp(30001, 806);
        chk("R6", "half range keeps ref", frm_kind, 0);

        cyc(1, 0, 0, 0, 0, 0, 0);
        begin
            int nxt = 1000;
            int prv = 999;
            for (int it = 0; it < 400; it++) begin
                int r = int'($urandom_range(0, 9));
                int oid;
                bit ov = (r != 9);
                if (r < 6) oid = prv + 1;
                else if (r == 6) oid = prv + 3;
                else if (r == 7) oid = prv;
                else oid = prv - 2;
                if (ov && oid > prv) prv = oid;
                cyc((it % 97) == 50, 1, nxt + 2, it * 3, ov, oid & 16'hFFFF, it * 7 + 50);
                nxt = oid + 1;
                if (nxt < prv) nxt = prv + 1;
            end
        end
        cmp_on = 0;
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule